// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Look-Ahead Output

This block is a first-in first-out buffer in which writer and reader share one clock. Its storage depth is a power of two, set by `ADDR_W` in the range 4 to 17. A build-time parameter `MODE` picks one of two ways to present data at the read side.

In the request mode (`CF_STANDARD`), the reader asks for a word with `rd_en` and the word appears on `dout` one cycle later, marked by `valid`. In the look-ahead mode (`CF_FWFT`), the oldest word is placed on `dout` without any request, and `rd_en` acknowledges it. The look-ahead path adds a prefetch register and an output register behind the storage. Those two registers raise the capacity by two words and widen the occupancy count by one bit.

A programmable-full flag with one cycle of lag helps a producer throttle itself. Reads while empty and writes while full are dropped inside the block.

Top module: `cc_fifo`

## Requirements
- R1: In request mode, an accepted read at a clock edge puts the oldest word on `dout` and drives `valid` high in the following cycle. `valid` is high only in the cycle after an edge where `rd_en` was 1 and `empty` was 0. After a write into an empty buffer, `empty` is 0 from the next cycle.
- R2: In request mode, `data_count` is `ADDR_W` bits wide and holds the occupancy modulo 2^ADDR_W. `full` is 1 exactly when 2^ADDR_W words are held, so the true occupancy is `{full, data_count}`.
- R3: In look-ahead mode, a word written into an empty buffer at edge k is on `dout` with `empty` at 0 after edge k+2, with no read. `valid` equals the inverse of `empty`. The head word and `dout` hold until a read acknowledges them.
- R4: In look-ahead mode, `data_count` is `ADDR_W+1` bits wide and counts every word held, up to 2^ADDR_W+2. `full` is 1 exactly at that count.
- R5: `prog_full` becomes 1 one cycle after `data_count` equals `pf_thresh`. It becomes 0 one cycle after `data_count` equals `pf_thresh-1` (taken modulo the count width). Otherwise it holds its value.
- R6: A read request while `empty` is 1 changes no count, no flag and no stored word.
- R7: A write request while `full` is 1 is dropped. The occupancy never exceeds the mode's capacity.
- R8: An accepted write together with an accepted read at the same edge leaves `data_count` unchanged.
- R9: While `rst_n` is 0 at a clock edge, the buffer empties: `data_count` goes to 0, `empty` to 1, and `valid`, `full` and `prog_full` go to 0.
- R10: Words leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| din | input | DATA_W | Write data |
| full | output | 1 | No room for another word |
| rd_en | input | 1 | Read request (request mode) or acknowledge (look-ahead mode) |
| dout | output | DATA_W | Read data |
| empty | output | 1 | No word available at the read side |
| valid | output | 1 | `dout` carries a word |
| data_count | output | CNT_W | Occupancy: ADDR_W bits in request mode, ADDR_W+1 in look-ahead mode |
| pf_thresh | input | CNT_W | Programmable-full threshold |
| prog_full | output | 1 | Programmable-full flag with one cycle of lag |

## Verification
The assertions assume that `rst_n` is low at the first clock edge and that every input carries a known value at each edge. The programmable-full checks also assume that `pf_thresh` changes only while reset is held. The bench therefore asserts reset from time zero and drives all inputs on the falling edge. It alters the thresholds only inside a reset window.

Random phases of the bench bias write and read rates differently, so that both instances pass repeatedly through empty, full and the threshold crossings. Directed sequences add reads on an empty buffer, overfilling, simultaneous read and write at full and mid-level, and a reset while words are held.

// File: rtl/cf_pkg.sv
// Package cf_pkg
// Shared definitions for the single-clock FIFO: output mode selection.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cf_pkg;

    // Read-side presentation style
    typedef enum logic {
        CF_STANDARD = 1'b0,  // word appears one cycle after a read request
        CF_FWFT     = 1'b1   // head word is presented without a request
    } cf_mode_e;

    // Width of the exported occupancy count for a given mode
    function automatic int cf_cnt_width(input int addr_w, input cf_mode_e mode);
        return (mode == CF_FWFT) ? addr_w + 1 : addr_w;
    endfunction

endpackage

// File: rtl/cf_ram.sv
// Module cf_ram
// Simple dual-port storage with one write port and one registered read port.
// A read and a write to the same address at one edge return the old word.
// Assumes the caller never reads an unwritten slot it relies on.
module cf_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Store the incoming word
    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    // Capture the addressed word when a read is issued
    always_ff @(posedge clk) begin
        if (rd_i) begin
            rd_q <= mem_q[rd_addr_i];
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/cf_ptrs.sv
// Module cf_ptrs
// Write and read pointers for the storage plus its own fill level.
// Assumes the caller pushes only with room (or with a pop in the same cycle)
// and pops only when the storage holds a word.
module cf_ptrs #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [ADDR_W:0]   fill_o
);
    localparam int              DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FILL_MAX = (ADDR_W+1)'(DEPTH);

    logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [ADDR_W:0]   fill_q;

    // Advance pointers and track how many words the storage holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
            fill_q <= fill_q + (ADDR_W+1)'(push_i) - (ADDR_W+1)'(pop_i);
        end
    end

    assign wr_addr_o = wr_ptr_q;
    assign rd_addr_o = rd_ptr_q;
    assign fill_o    = fill_q;

    // R6: storage is never popped while it is empty
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (fill_q != '0));

    // R7: a push into full storage only happens while a word leaves
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && fill_q == FILL_MAX) |-> pop_i);

endmodule

// File: rtl/cf_level.sv
// Module cf_level
// Total occupancy counter with full detection and a lagging programmable-full flag.
// Assumes inc_i is never set at capacity and dec_i never at zero; the count
// moves by at most one per cycle.
module cf_level #(
    parameter int OCC_W   = 5,
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic [OCC_W-1:0] occ_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             pf_o
);
    localparam logic [OCC_W-1:0] OCC_CAP = OCC_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [OCC_W-1:0] occ_q;
    logic             pf_q;
    logic [CNT_W-1:0] cnt_view;
    logic [CNT_W-1:0] thresh_lo;

    assign cnt_view  = occ_q[CNT_W-1:0];
    assign thresh_lo = thresh_i - ONE;

    // Occupancy follows accepted writes and reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(inc_i) - OCC_W'(dec_i);
        end
    end

    // Programmable-full: set at threshold, clear at threshold minus one, one cycle late
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
        end else if (cnt_view == thresh_i) begin
            pf_q <= 1'b1;
        end else if (cnt_view == thresh_lo) begin
            pf_q <= 1'b0;
        end
    end

    assign occ_o   = occ_q;
    assign count_o = cnt_view;
    assign full_o  = (occ_q == OCC_CAP);
    assign pf_o    = pf_q;

    // R5: flag follows an equal count one cycle later
    p_pf_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == thresh_i) |=> pf_o);

    // R5: flag drops one cycle after the count sits one below the threshold
    p_pf_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == thresh_lo && count_o != thresh_i) |=> !pf_o);

    // R8: accepted write and read together keep the level
    p_rw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(occ_o));

    // R7: level stays within capacity
    p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ_o <= OCC_CAP);

    // R9: reset clears level and flag
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (occ_o == '0 && !pf_o));

endmodule

// File: rtl/cc_fifo.sv
// Module cc_fifo
// Single-clock FIFO. MODE picks request-style output (data one cycle after
// rd_en) or look-ahead output (head word shown without a request, two extra
// words of capacity). Reads while empty and writes while full are dropped.
// Assumes ADDR_W in 4..17 and pf_thresh held stable outside reset.
module cc_fifo #(
    parameter int               DATA_W = 8,
    parameter int               ADDR_W = 4,
    parameter cf_pkg::cf_mode_e MODE   = cf_pkg::CF_STANDARD,
    localparam int              CNT_W  = cf_pkg::cf_cnt_width(ADDR_W, MODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              valid,
    output logic [CNT_W-1:0]  data_count,
    input  logic [CNT_W-1:0]  pf_thresh,
    output logic              prog_full
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int OCC_W   = ADDR_W + 1;
    localparam int CNT_MAX = (MODE == cf_pkg::CF_FWFT) ? DEPTH + 2 : DEPTH;

    logic              wr_ok, rd_ok;
    logic              pop_w, empty_w, valid_w;
    logic [DATA_W-1:0] dout_w, ram_q;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [ADDR_W:0]   mem_fill;
    logic [OCC_W-1:0]  occ;
    logic              full_w;

    assign wr_ok = wr_en & ~full_w;
    assign rd_ok = rd_en & ~empty_w;

    cf_ptrs #(.ADDR_W(ADDR_W)) ptrs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (wr_ok),
        .pop_i     (pop_w),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .fill_o    (mem_fill)
    );

    cf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
        .clk       (clk),
        .wr_i      (wr_ok),
        .wr_addr_i (wr_addr),
        .wr_data_i (din),
        .rd_i      (pop_w),
        .rd_addr_i (rd_addr),
        .rd_data_o (ram_q)
    );

    cf_level #(.OCC_W(OCC_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) level_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (wr_ok),
        .dec_i    (rd_ok),
        .thresh_i (pf_thresh),
        .occ_o    (occ),
        .count_o  (data_count),
        .full_o   (full_w),
        .pf_o     (prog_full)
    );

    generate
        if (MODE == cf_pkg::CF_FWFT) begin : g_fwft
            logic              pre_v_q, out_v_q;
            logic [DATA_W-1:0] out_q;
            logic              out_load;

            assign out_load = pre_v_q & (~out_v_q | rd_ok);
            assign pop_w    = (mem_fill != '0) & (~pre_v_q | out_load);

            // Move words storage -> prefetch register -> output register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_v_q <= 1'b0;
                    out_v_q <= 1'b0;
                end else begin
                    pre_v_q <= pop_w | (pre_v_q & ~out_load);
                    out_v_q <= out_load | (out_v_q & ~rd_ok);
                end
            end

            // Load the output word from the prefetch register
            always_ff @(posedge clk) begin
                if (out_load) begin
                    out_q <= ram_q;
                end
            end

            assign dout_w  = out_q;
            assign empty_w = ~out_v_q;
            assign valid_w = out_v_q;

            // R3: an unacknowledged head word stays put
            p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (out_v_q && !rd_en) |=> (out_v_q && $stable(out_q)));

            // R4: a shown word is always counted
            p_shown_counted_r4: assert property (@(posedge clk) disable iff (!rst_n)
                out_v_q |-> (occ != '0));
        end else begin : g_std
            logic valid_q;

            assign pop_w = rd_ok;

            // Mark the cycle after an accepted read
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                end else begin
                    valid_q <= rd_ok;
                end
            end

            assign dout_w  = ram_q;
            assign empty_w = (occ == '0);
            assign valid_w = valid_q;

            // R1: valid only after a read that found data
            p_valid_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
                valid_q |-> $past(rd_en && !empty_w));

            // R1: a read that finds data is always answered
            p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && !empty_w) |=> valid_q);

            // R2: storage fill and total level agree in this mode
            p_fill_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
                mem_fill == occ);
        end
    endgenerate

    assign full  = full_w;
    assign empty = empty_w;
    assign valid = valid_w;
    assign dout  = dout_w;

endmodule

// File: tb/cc_fifo_tb_top.sv
// Bench for cc_fifo: a request-mode and a look-ahead-mode instance share
// stimulus; each is compared every cycle with a queue-based reference model.
module cc_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int DW         = 8;
    localparam int DEPTH      = 1 << AW;
    localparam int F_CAP      = DEPTH + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] th_s = AW'(12);
    logic [AW:0]   th_f = (AW+1)'(17);

    logic          s_full, s_empty, s_valid, s_pf;
    logic [DW-1:0] s_dout;
    logic [AW-1:0] s_dc;
    logic          f_full, f_empty, f_valid, f_pf;
    logic [DW-1:0] f_dout;
    logic [AW:0]   f_dc;

    int checks = 0;
    int errors = 0;

    cc_fifo #(.DATA_W(DW), .ADDR_W(AW), .MODE(cf_pkg::CF_STANDARD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .full(s_full),
        .rd_en(rd_en), .dout(s_dout), .empty(s_empty), .valid(s_valid),
        .data_count(s_dc), .pf_thresh(th_s), .prog_full(s_pf)
    );

    cc_fifo #(.DATA_W(DW), .ADDR_W(AW), .MODE(cf_pkg::CF_FWFT)) dut_fw_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .full(f_full),
        .rd_en(rd_en), .dout(f_dout), .empty(f_empty), .valid(f_valid),
        .data_count(f_dc), .pf_thresh(th_f), .prog_full(f_pf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    logic [DW-1:0] sq[$];
    logic [DW-1:0] fq[$];
    int            ft[$];
    int            edge_n = 0;
    logic [DW-1:0] s_dout_m = '0;
    bit            s_valid_m = 0, s_pf_m = 0, f_pf_m = 0;

    // Head word of the look-ahead model is shown two edges after its write
    function automatic bit f_vis();
        return (fq.size() > 0) && (ft[0] <= edge_n - 2);
    endfunction

    // Next programmable-full value from the count seen before an edge
    function automatic bit pf_next(input int cnt, input int th, input int modv, input bit cur);
        if (cnt == th) return 1'b1;
        if (cnt == ((th + modv - 1) % modv)) return 1'b0;
        return cur;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Advance both models across one rising edge
    task automatic model_edge(input bit w, input bit r, input logic [DW-1:0] d, input bit in_rst);
        int  sc, fc;
        bit  s_rd, s_wr, f_rd, f_wr;
        if (in_rst) begin
            sq.delete(); fq.delete(); ft.delete();
            s_valid_m = 0; s_pf_m = 0; f_pf_m = 0;
            edge_n++;
            return;
        end
        sc   = sq.size();
        s_rd = r && (sc != 0);
        s_wr = w && (sc != DEPTH);
        s_pf_m    = pf_next(sc % DEPTH, int'(th_s), DEPTH, s_pf_m);
        s_valid_m = s_rd;
        if (s_rd) s_dout_m = sq.pop_front();
        if (s_wr) sq.push_back(d);

        fc   = fq.size();
        f_rd = r && f_vis();
        f_wr = w && (fc != F_CAP);
        f_pf_m = pf_next(fc, int'(th_f), 2*DEPTH, f_pf_m);
        if (f_rd) begin
            void'(fq.pop_front());
            void'(ft.pop_front());
        end
        if (f_wr) begin
            fq.push_back(d);
            ft.push_back(edge_n + 1);
        end
        edge_n++;
    endtask

    // Compare every output of both instances with the models
    task automatic compare();
        chk("R2 R6 std empty", int'(s_empty), int'(sq.size() == 0));
        chk("R2 R7 std full", int'(s_full), int'(sq.size() == DEPTH));
        chk("R2 R8 std data_count", int'(s_dc), sq.size() % DEPTH);
        chk("R1 std valid", int'(s_valid), int'(s_valid_m));
        if (s_valid_m) chk("R1 R10 std dout", int'(s_dout), int'(s_dout_m));
        chk("R5 std prog_full", int'(s_pf), int'(s_pf_m));
        chk("R3 R6 fwft empty", int'(f_empty), int'(!f_vis()));
        chk("R3 fwft valid", int'(f_valid), int'(f_vis()));
        if (f_vis()) chk("R3 R10 fwft dout", int'(f_dout), int'(fq[0]));
        chk("R4 R7 fwft full", int'(f_full), int'(fq.size() == F_CAP));
        chk("R4 R8 fwft data_count", int'(f_dc), fq.size());
        chk("R5 fwft prog_full", int'(f_pf), int'(f_pf_m));
    endtask

    // One cycle: drive at the falling edge, model the rising edge, check at the next fall
    task automatic step(input bit w, input bit r, input logic [DW-1:0] d);
        wr_en = w; rd_en = r; din = d;
        @(posedge clk);
        model_edge(w, r, d, !rst_n);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(input int ts, input int tf);
        rst_n = 1'b0;
        th_s = AW'(ts);
        th_f = (AW+1)'(tf);
        step(1'b1, 1'b1, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        // R9: state right after reset
        chk("R9 std data_count", int'(s_dc), 0);
        chk("R9 std empty", int'(s_empty), 1);
        chk("R9 std valid", int'(s_valid), 0);
        chk("R9 std full", int'(s_full), 0);
        chk("R9 std prog_full", int'(s_pf), 0);
        chk("R9 fwft data_count", int'(f_dc), 0);
        chk("R9 fwft empty", int'(f_empty), 1);
        chk("R9 fwft prog_full", int'(f_pf), 0);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED_0C0F);
        @(negedge clk);
        do_reset(12, 17);

        // R6: reads on an empty buffer
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'h00);
        chk("R6 std count after empty reads", int'(s_dc), 0);
        chk("R6 fwft count after empty reads", int'(f_dc), 0);
        chk("R6 std no valid", int'(s_valid), 0);

        // R1 / R3: one word into an empty buffer
        step(1'b1, 1'b0, 8'hA5);
        chk("R1 std not empty after write", int'(s_empty), 0);
        chk("R3 fwft hidden one edge after write", int'(f_empty), 1);
        step(1'b0, 1'b0, 8'h00);
        chk("R3 fwft hidden two edges in", int'(f_empty), 1);
        step(1'b0, 1'b0, 8'h00);
        chk("R3 fwft shown", int'(f_empty), 0);
        chk("R3 fwft head word", int'(f_dout), 8'hA5);
        step(1'b0, 1'b1, 8'h00);
        chk("R1 std valid after read", int'(s_valid), 1);
        chk("R1 std word after read", int'(s_dout), 8'hA5);

        // R7 / R2 / R4: overfill
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, DW'(i + 1));
        chk("R2 std full", int'(s_full), 1);
        chk("R7 std count wraps to zero at full", int'(s_dc), 0);
        chk("R4 fwft count at capacity", int'(f_dc), F_CAP);
        chk("R7 fwft full", int'(f_full), 1);

        // R8: read+write at full, then at a mid level
        step(1'b1, 1'b1, 8'hEE);
        step(1'b1, 1'b1, 8'hEF);
        chk("R8 std count held", int'(s_dc), DEPTH - 1);
        chk("R8 fwft count held", int'(f_dc), F_CAP - 1);

        // drain, including extra empty reads
        for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 8'h00);
        chk("R6 std drained", int'(s_dc), 0);

        // R9: reset with words held, new thresholds
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, DW'(8'h30 + i));
        do_reset(5, 3);

        // random phases with different read/write biases
        for (int ph = 0; ph < 8; ph++) begin
            int pw, pr;
            pw = 20 + int'($urandom_range(0, 70));
            pr = 20 + int'($urandom_range(0, 70));
            for (int c = 0; c < 500; c++) begin
                bit w, r;
                w = (int'($urandom_range(0, 99)) < pw);
                r = (int'($urandom_range(0, 99)) < pr);
                step(w, r, DW'($urandom));
            end
            if (ph == 3) do_reset(12, 17);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule